// File: doc/BRIEF.md
# Edge/Level Interrupt Pending and Dispatch Core

This block is the decision core of an interrupt controller. Each source is set to edge or level mode. The core keeps four per-source state vectors: a pending vector, an in-service vector, a recorded-level vector and a mask vector. One input event, one mask update or one clear command is handled per clock. Each action checks a candidate set of sources and acts only on the lowest-numbered source in that set. It marks that source in service, or takes it out of service, and drives the parent output line chosen by that source's entry in a programmable vector table.

The surrounding register decoder sends four command kinds over one command port: mask update, trigger-mode update, clear and vector-table write. Input level changes arrive as single-cycle events that carry a source index and the new level. Each parent line is a register, and it holds its value until a later dispatch changes it. The status output is the in-service vector with the masked sources removed.

Top module: `irq_dispatch_core`

## Requirements
- R1: After reset, every source is masked (mask all ones), trigger mode is level (0) for every source, all vector entries are 0, all parent lines are low and status is 0. An input event on a masked source therefore drives no parent line.
- R2: In edge mode (trigger bit 1), a rising event sets pending only if the recorded level was low. A falling event updates only the recorded level, so pending survives. A masked edge source that rose and fell is dispatched when it is later unmasked.
- R3: In level mode (trigger bit 0), pending and the recorded level both follow the event level. A masked level source that rose and then fell is not dispatched when unmasked.
- R4: A rising event whose source is pending and unmasked marks that source in service, sets its status bit and drives its vector-selected parent line high on the next clock.
- R5: A falling event takes its source out of service and drives its vector-selected parent line low, but only when the source is in service and no longer pending. A falling edge-mode source stays in service.
- R6: A mask update (cmd_op 0) writes mask bits where cmd_wmask is 1. For the bits it turns from 1 to 0, only the lowest-numbered pending source is dispatched. The others stay pending and are not in service.
- R7: For the bits a mask update turns from 0 to 1, the falling evaluation runs. A source that is still pending keeps its parent line high.
- R8: A clear (cmd_op 2) acts only if some bit of cmd_data is an edge-mode source. It then clears pending for all written bits, lowers the parent line of the lowest such bit that was in service, and clears in-service for all written bits. A clear that writes only level-mode bits changes nothing.
- R9: Status equals in-service AND NOT mask, so a source that is in service but masked reads 0.
- R10: A vector write (cmd_op 3) stores cmd_data[VEC_W-1:0] as the entry for source cmd_index. A dispatched source whose entry is NUM_PARENT or more drives no parent line but is still marked in service. A trigger write is cmd_op 1.
- R11: When cmd_valid and evt_valid are both high in one cycle, the command is executed and the input event is discarded, not deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Input level event strobe |
| evt_src | input | SRC_IW | Source index of the event |
| evt_level | input | 1 | New input level of that source |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 mask, 1 trigger mode, 2 clear, 3 vector write |
| cmd_wmask | input | NUM_SRC | Bit enable for mask and trigger writes |
| cmd_data | input | NUM_SRC | Write data or clear bits; low VEC_W bits carry a vector entry |
| cmd_index | input | SRC_IW | Source index for vector writes |
| parent_irq | output | NUM_PARENT | Parent output lines |
| status | output | NUM_SRC | In-service sources that are not masked |

## Verification
The bench builds the core with 16 sources, 8 parent lines and 4-bit vector entries. This puts vector values 8 to 15 within reach, so the out-of-range entry case can be driven directly. It also keeps every expected parent and status word short enough to be worked out by hand. Those settings still leave room for the cases that matter: a multi-bit unmask where only the lowest source is dispatched, edge pending that outlives a falling input, clear commands with and without an edge-mode bit, and a command that collides with an event.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

   typedef enum logic [1:0] {
      CMD_MASK   = 2'd0,
      CMD_TRIG   = 2'd1,
      CMD_CLEAR  = 2'd2,
      CMD_VECTOR = 2'd3
   } cmd_op_e;

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int W  = 64,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  cand,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = |cand;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (cand[i]) idx = IW'(i);
      end
   end

   always_comb begin
      if (found) assert (cand[idx]);
   end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
   parameter int NUM_SRC = 64,
   parameter int VEC_W   = 8,
   parameter int SRC_IW  = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SRC_IW-1:0] widx,
   input  logic [VEC_W-1:0]  wdata,
   input  logic [SRC_IW-1:0] ridx_a,
   output logic [VEC_W-1:0]  rdata_a,
   input  logic [SRC_IW-1:0] ridx_b,
   output logic [VEC_W-1:0]  rdata_b
);

   logic [VEC_W-1:0] tbl [NUM_SRC];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl[g] <= '0;
         else if (we && widx == SRC_IW'(g))
            tbl[g] <= wdata;
      end
   end

   assign rdata_a = tbl[ridx_a];
   assign rdata_b = tbl[ridx_b];

endmodule

// File: rtl/irq_dispatch_core.sv
module irq_dispatch_core
   import irq_dispatch_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int NUM_PARENT = 64,
   parameter int VEC_W      = 8,
   localparam int SRC_IW    = $clog2(NUM_SRC),
   localparam int PW        = $clog2(NUM_PARENT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_valid,
   input  logic [SRC_IW-1:0]     evt_src,
   input  logic                  evt_level,
   input  logic                  cmd_valid,
   input  logic [1:0]            cmd_op,
   input  logic [NUM_SRC-1:0]    cmd_wmask,
   input  logic [NUM_SRC-1:0]    cmd_data,
   input  logic [SRC_IW-1:0]     cmd_index,
   output logic [NUM_PARENT-1:0] parent_irq,
   output logic [NUM_SRC-1:0]    status
);

   localparam logic [VEC_W:0] PAR_LIM = (VEC_W + 1)'(NUM_PARENT);

   initial begin
      assert (NUM_SRC >= 2 && NUM_SRC <= 1024)
         else $fatal(1, "NUM_SRC out of range");
      assert (NUM_PARENT >= 2 && NUM_PARENT <= 2 ** VEC_W)
         else $fatal(1, "NUM_PARENT must fit the vector width");
      assert (VEC_W >= 1 && VEC_W <= NUM_SRC)
         else $fatal(1, "VEC_W must fit in cmd_data");
   end

   logic [NUM_SRC-1:0]    irr_q, isr_q, last_q, mask_q, trig_q;
   logic [NUM_SRC-1:0]    irr_n, isr_n, last_n, mask_n, trig_n, isr_f;
   logic [NUM_SRC-1:0]    rise_set, fall_set, ebit;
   logic [NUM_PARENT-1:0] par_q, par_n;
   logic                  clr_act;

   logic                  rise_found, fall_found;
   logic [SRC_IW-1:0]     rise_idx, fall_idx;
   logic [VEC_W-1:0]      rise_vec, fall_vec;
   logic                  rise_ok, fall_ok;

   // Vector table: one entry per source, written by the vector command
   irq_vec_table #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .SRC_IW(SRC_IW)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cmd_valid && cmd_op == CMD_VECTOR),
      .widx    (cmd_index),
      .wdata   (cmd_data[VEC_W-1:0]),
      .ridx_a  (rise_idx),
      .rdata_a (rise_vec),
      .ridx_b  (fall_idx),
      .rdata_b (fall_vec)
   );

   irq_lowest_pick #(.W(NUM_SRC), .IW(SRC_IW)) u_rise_pick (
      .cand (rise_set), .found (rise_found), .idx (rise_idx)
   );

   irq_lowest_pick #(.W(NUM_SRC), .IW(SRC_IW)) u_fall_pick (
      .cand (fall_set), .found (fall_found), .idx (fall_idx)
   );

   assign rise_ok = {1'b0, rise_vec} < PAR_LIM;
   assign fall_ok = {1'b0, fall_vec} < PAR_LIM;

   // State update and candidate sets; a command wins over an event
   always_comb begin
      irr_n    = irr_q;
      last_n   = last_q;
      mask_n   = mask_q;
      trig_n   = trig_q;
      rise_set = '0;
      fall_set = '0;
      clr_act  = 1'b0;
      ebit     = '0;
      ebit[evt_src] = 1'b1;
      if (cmd_valid) begin
         case (cmd_op)
            CMD_MASK: begin
               mask_n   = (mask_q & ~cmd_wmask) | (cmd_data & cmd_wmask);
               rise_set = mask_q & ~mask_n & irr_q;
               fall_set = ~mask_q & mask_n & isr_q & ~irr_q;
            end
            CMD_TRIG: trig_n = (trig_q & ~cmd_wmask) | (cmd_data & cmd_wmask);
            CMD_CLEAR: begin
               if (|(trig_q & cmd_data)) begin
                  clr_act  = 1'b1;
                  irr_n    = irr_q & ~cmd_data;
                  fall_set = cmd_data & isr_q & ~irr_n;
               end
            end
            default: ;
         endcase
      end else if (evt_valid) begin
         if (trig_q[evt_src]) begin
            if (evt_level) begin
               if (!last_q[evt_src]) irr_n[evt_src] = 1'b1;
               last_n[evt_src] = 1'b1;
            end else begin
               last_n[evt_src] = 1'b0;
            end
         end else begin
            irr_n[evt_src]  = evt_level;
            last_n[evt_src] = evt_level;
         end
         if (evt_level) rise_set = ebit & irr_n & ~mask_q;
         else           fall_set = ebit & isr_q & ~irr_n;
      end
   end

   // In-service and parent line update: raise first, then lower
   always_comb begin
      isr_n = isr_q;
      par_n = par_q;
      if (rise_found) begin
         isr_n[rise_idx] = 1'b1;
         if (rise_ok) par_n[rise_vec[PW-1:0]] = 1'b1;
      end
      if (fall_found) begin
         isr_n[fall_idx] = 1'b0;
         if (fall_ok) par_n[fall_vec[PW-1:0]] = 1'b0;
      end
      isr_f = clr_act ? (isr_n & ~cmd_data) : isr_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q  <= '0;
         isr_q  <= '0;
         last_q <= '0;
         mask_q <= '1;
         trig_q <= '0;
         par_q  <= '0;
      end else begin
         irr_q  <= irr_n;
         isr_q  <= isr_f;
         last_q <= last_n;
         mask_q <= mask_n;
         trig_q <= trig_n;
         par_q  <= par_n;
      end
   end

   assign parent_irq = par_q;
   assign status     = isr_q & ~mask_q;

   // R2: edge rise from a low recorded level leaves the source pending
   p_edge_rise_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !cmd_valid && trig_q[evt_src] && evt_level && !last_q[evt_src]
      |=> irr_q[$past(evt_src)]);

   // R2: edge fall leaves pending untouched
   p_edge_fall_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !cmd_valid && trig_q[evt_src] && !evt_level
      |=> $stable(irr_q));

   // R3: level-mode pending follows the event level
   p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !cmd_valid && !trig_q[evt_src]
      |=> irr_q[$past(evt_src)] == $past(evt_level));

   // R6: the mask changes only through a mask command
   p_mask_only_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_op == CMD_MASK) |=> $stable(mask_q));

   // R8: a clear with no edge-mode bit changes nothing
   p_clear_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == CMD_CLEAR && !(|(cmd_data & trig_q))
      |=> $stable(irr_q) && $stable(isr_q) && $stable(par_q));

   // R11: an event that collides with a command leaves no trace
   p_evt_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> $stable(last_q));

   // R4: parent lines move only in response to an event or command
   p_par_needs_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid && !cmd_valid |=> $stable(par_q));

endmodule

// File: tb/irq_dispatch_core_bench.sv
module irq_dispatch_core_bench;
   import irq_dispatch_pkg::*;

   localparam int NS = 16;
   localparam int NP = 8;
   localparam int VW = 4;
   localparam int IW = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0;
   logic [IW-1:0] evt_src = '0;
   logic          evt_level = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = '0;
   logic [NS-1:0] cmd_wmask = '0;
   logic [NS-1:0] cmd_data = '0;
   logic [IW-1:0] cmd_index = '0;
   logic [NP-1:0] parent_irq;
   logic [NS-1:0] status;

   always #10 clk = ~clk;

   irq_dispatch_core #(.NUM_SRC(NS), .NUM_PARENT(NP), .VEC_W(VW)) u_irq_dispatch_core (
      .clk (clk), .rst_n (rst_n),
      .evt_valid (evt_valid), .evt_src (evt_src), .evt_level (evt_level),
      .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_wmask (cmd_wmask),
      .cmd_data (cmd_data), .cmd_index (cmd_index),
      .parent_irq (parent_irq), .status (status)
   );

   typedef struct {
      string         tag;
      logic [NP-1:0] par;
      logic [NS-1:0] st;
   } exp_t;

   exp_t q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // Monitor: compare one expected item per falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_run++;
         if (parent_irq !== e.par || status !== e.st) begin
            n_fail++;
            $display("FAIL %s: parent=%h status=%h expected parent=%h status=%h",
                     e.tag, parent_irq, status, e.par, e.st);
         end
      end
   end

   task automatic push(input string tag, input logic [NP-1:0] p, input logic [NS-1:0] s);
      exp_t e;
      e.tag = tag; e.par = p; e.st = s;
      q.push_back(e);
   endtask

   task automatic idle_inputs();
      evt_valid = 1'b0;
      cmd_valid = 1'b0;
   endtask

   task automatic do_evt(input int src, input logic lvl, input string tag,
                         input logic [NP-1:0] p, input logic [NS-1:0] s);
      @(negedge clk);
      evt_valid = 1'b1; evt_src = IW'(src); evt_level = lvl;
      @(posedge clk); #1;
      idle_inputs();
      push(tag, p, s);
   endtask

   task automatic do_cmd(input cmd_op_e op, input logic [NS-1:0] wm, input logic [NS-1:0] d,
                         input int idx, input string tag,
                         input logic [NP-1:0] p, input logic [NS-1:0] s);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_wmask = wm; cmd_data = d; cmd_index = IW'(idx);
      @(posedge clk); #1;
      idle_inputs();
      push(tag, p, s);
   endtask

   task automatic do_both(input int src, input logic lvl, input cmd_op_e op,
                          input logic [NS-1:0] wm, input logic [NS-1:0] d, input string tag,
                          input logic [NP-1:0] p, input logic [NS-1:0] s);
      @(negedge clk);
      evt_valid = 1'b1; evt_src = IW'(src); evt_level = lvl;
      cmd_valid = 1'b1; cmd_op = op; cmd_wmask = wm; cmd_data = d;
      @(posedge clk); #1;
      idle_inputs();
      push(tag, p, s);
   endtask

   task automatic do_idle(input string tag, input logic [NP-1:0] p, input logic [NS-1:0] s);
      @(negedge clk);
      @(posedge clk); #1;
      push(tag, p, s);
   endtask

   task automatic set_vec(input int src, input int v);
      do_cmd(CMD_VECTOR, '0, NS'(v), src, "R10 vector write", 8'h00, 16'h0000);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push("R1 reset state", 8'h00, 16'h0000);

      do_evt(0, 1'b1, "R1 masked source stays quiet", 8'h00, 16'h0000);

      set_vec(0, 2); set_vec(1, 3); set_vec(2, 5); set_vec(3, 9);
      set_vec(4, 1); set_vec(5, 6); set_vec(6, 7); set_vec(7, 4);

      do_cmd(CMD_MASK, 16'h0001, 16'h0000, 0, "R4 unmask pending level src0", 8'h04, 16'h0001);
      do_evt(0, 1'b0, "R5 level fall lowers line", 8'h00, 16'h0000);

      do_cmd(CMD_TRIG, 16'h0006, 16'h0006, 0, "R2 edge mode on src1 src2", 8'h00, 16'h0000);
      do_cmd(CMD_MASK, 16'h003E, 16'h0000, 0, "R6 unmask with nothing pending", 8'h00, 16'h0000);

      do_evt(1, 1'b1, "R2 edge rise dispatches", 8'h08, 16'h0002);
      do_evt(1, 1'b0, "R5 edge fall keeps in service", 8'h08, 16'h0002);
      do_evt(1, 1'b1, "R2 repeat rise no change", 8'h08, 16'h0002);

      do_cmd(CMD_CLEAR, '0, 16'h0001, 0, "R8 clear of level-only bit ignored", 8'h08, 16'h0002);
      do_cmd(CMD_CLEAR, '0, 16'h0002, 0, "R8 clear edge source", 8'h00, 16'h0000);

      do_evt(7, 1'b1, "R6 masked src7 pending", 8'h00, 16'h0000);
      do_evt(6, 1'b1, "R6 masked src6 pending", 8'h00, 16'h0000);
      do_cmd(CMD_MASK, 16'h00C0, 16'h0000, 0, "R6 only lowest dispatched", 8'h80, 16'h0040);
      do_evt(6, 1'b0, "R5 src6 fall", 8'h00, 16'h0000);
      do_evt(7, 1'b1, "R6 src7 left pending then dispatched", 8'h10, 16'h0080);

      do_cmd(CMD_MASK, 16'h0080, 16'h0080, 0, "R7 R9 mask pending in-service src7", 8'h10, 16'h0000);
      do_evt(7, 1'b0, "R5 masked in-service src7 fall", 8'h00, 16'h0000);

      do_evt(3, 1'b1, "R10 out-of-range vector drives nothing", 8'h00, 16'h0008);
      do_evt(3, 1'b0, "R10 out-of-range vector release", 8'h00, 16'h0000);

      do_both(4, 1'b1, CMD_TRIG, 16'h0400, 16'h0400, "R11 event dropped on collision", 8'h00, 16'h0000);
      do_idle("R11 event not deferred", 8'h00, 16'h0000);
      do_evt(4, 1'b1, "R4 src4 dispatch to line 1", 8'h02, 16'h0010);

      do_cmd(CMD_MASK, 16'h0004, 16'h0004, 0, "R2 mask src2", 8'h02, 16'h0010);
      do_evt(2, 1'b1, "R2 masked edge rise", 8'h02, 16'h0010);
      do_evt(2, 1'b0, "R2 masked edge fall", 8'h02, 16'h0010);
      do_cmd(CMD_MASK, 16'h0004, 16'h0000, 0, "R2 edge pending survives fall", 8'h22, 16'h0014);

      do_cmd(CMD_MASK, 16'h0020, 16'h0020, 0, "R3 mask src5", 8'h22, 16'h0014);
      do_evt(5, 1'b1, "R3 masked level rise", 8'h22, 16'h0014);
      do_evt(5, 1'b0, "R3 masked level fall", 8'h22, 16'h0014);
      do_cmd(CMD_MASK, 16'h0020, 16'h0000, 0, "R3 level pending gone", 8'h22, 16'h0014);

      repeat (3) @(posedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule